// File: doc/BRIEF.md
# Flash Controller Lock and Status Register Front End

This block is the software-facing register file of an embedded flash controller. It decodes a small word-indexed 32-bit write bus with per-byte enables and presents three registers: a key register for unlocking, a status register with two sticky flags, and a control register. The control register holds the operation selection, the interrupt enables, a start bit and a lock bit. A flash engine outside this block consumes a one-cycle start pulse and the operation fields. It reports back through busy, done and error inputs.

The control register comes out of reset locked. Software opens it by writing two key words in order to the key register. One wrong, partial or out-of-order key write fails the attempt, and the register then stays locked until the next reset. A single interrupt output is asserted as a level while either status flag is set together with its enable.

Top module: `flashreg_top`

## Requirements
- R1: After reset the control register (word index 2) reads 0x8000_0000, the status register (word index 1) reads 0, and irq and op_start are 0.
- R2: A full-word write of KEY1 (0x1A2B_3C4D) to the key register (word index 0), followed by a full-word write of KEY2 (0xE5F6_0718), clears control bit 31 (lock) after the second write's clock edge.
- R3: A key write with any other value, with an order other than KEY1 then KEY2, or with any byte enable low leaves the block locked until reset. A correct key sequence afterwards does not unlock it.
- R4: While unlocked, writing 1 to control bit 31 (byte lane 3) sets the lock again, and the key sequence then unlocks it again. Writing 0 to bit 31 has no effect.
- R5: While locked, every write to the control register leaves its read value and the op outputs unchanged.
- R6: The control fields are program enable at bit 0, sector erase at bit 1, mass erase at bit 2, sector number at bits 6:3, program size at bits 9:8, start at bit 16, end-of-operation enable at bit 24 and error enable at bit 25. Reserved bits read 0. A byte whose enable is low is not written.
- R7: Writing 1 to bit 16 while unlocked, idle and with start clear sets bit 16 and pulses op_start high for exactly the one cycle after the write edge. Writing 0 to bit 16 has no effect.
- R8: The start bit clears at the clock edge after eng_busy falls.
- R9: While eng_busy is high, writes to bits 9:0 and 16 are ignored, no op_start pulse is produced, and a start request counts as an error event.
- R10: Status bit 0 (end of operation) is set by eng_done only when bit 24 is 1.
- R11: Status bit 1 (operation error) is set by eng_err or a busy start request only when bit 25 is 1.
- R12: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R13: irq is high exactly while (status bit 0 AND bit 24) OR (status bit 1 AND bit 25).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_idx | input | 2 | Word index: 0 key, 1 status, 2 control |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte enables |
| bus_rdata | output | 32 | Read data for bus_idx, no wait state |
| eng_busy | input | 1 | Engine operation in progress |
| eng_done | input | 1 | Engine finished an operation successfully |
| eng_err | input | 1 | Engine detected a request error |
| op_start | output | 1 | One-cycle launch pulse |
| op_pg | output | 1 | Program enable |
| op_ser | output | 1 | Sector erase |
| op_mer | output | 1 | Mass erase |
| op_sector | output | 4 | Sector number |
| op_psize | output | 2 | Program size |
| irq | output | 1 | Level interrupt |

## Verification
A wrong lock state shows up on the first control read after the key writes. Bit 31 reads wrong, and a later field write either sticks or is lost one cycle later. A wrong start handshake shows up at op_start in the cycle right after the write, or in bit 16 one cycle after busy falls. Flag or enable errors show on irq and the status read in the cycle after the event or the clearing write.

// File: rtl/flashreg_pkg.sv
package flashreg_pkg;
    typedef enum logic [1:0] {
        LK_WAIT_K1,
        LK_WAIT_K2,
        LK_OPEN,
        LK_DEAD
    } lock_state_t;

    localparam logic [1:0] IDX_KEY  = 2'd0;
    localparam logic [1:0] IDX_STAT = 2'd1;
    localparam logic [1:0] IDX_CTRL = 2'd2;

    localparam int SNB_W     = 4;
    localparam int PSZ_W     = 2;
    localparam int BIT_PG    = 0;
    localparam int BIT_SER   = 1;
    localparam int BIT_MER   = 2;
    localparam int SNB_LSB   = 3;
    localparam int PSZ_LSB   = 8;
    localparam int BIT_STRT  = 16;
    localparam int BIT_EOPIE = 24;
    localparam int BIT_ERRIE = 25;
    localparam int BIT_LOCK  = 31;
endpackage

// File: rtl/flashreg_lockfsm.sv
module flashreg_lockfsm
    import flashreg_pkg::*;
#(
    parameter logic [31:0] KEY1 = 32'h1A2B_3C4D,
    parameter logic [31:0] KEY2 = 32'hE5F6_0718
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        key_wr,
    input  logic        key_full,
    input  logic [31:0] key_data,
    input  logic        relock_req,
    output logic        locked,
    output logic        dead
);
    lock_state_t st, st_nxt;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= LK_WAIT_K1;
        else        st <= st_nxt;
    end

    always_comb begin
        st_nxt = st;
        unique case (st)
            LK_WAIT_K1: if (key_wr) st_nxt = (key_full && key_data == KEY1) ? LK_WAIT_K2 : LK_DEAD;
            LK_WAIT_K2: if (key_wr) st_nxt = (key_full && key_data == KEY2) ? LK_OPEN : LK_DEAD;
            LK_OPEN:    if (relock_req) st_nxt = LK_WAIT_K1;
            LK_DEAD:    st_nxt = LK_DEAD;
            default:    st_nxt = LK_DEAD;
        endcase
    end

    always_comb begin
        locked = (st != LK_OPEN);
        dead   = (st == LK_DEAD);
    end
endmodule

// File: rtl/flashreg_ctrl.sv
module flashreg_ctrl
    import flashreg_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [3:0]       be,
    input  logic [31:0]      wdata,
    input  logic             locked,
    input  logic             busy,
    output logic             pg,
    output logic             ser,
    output logic             mer,
    output logic [SNB_W-1:0] snb,
    output logic [PSZ_W-1:0] psize,
    output logic             strt,
    output logic             eopie,
    output logic             errie,
    output logic             start_pulse,
    output logic             start_busy,
    output logic             relock_req
);
    logic busy_q;
    logic unl_wr;
    logic start_req;
    logic start_ok;
    logic unused_bits;

    assign unl_wr      = wr && !locked;
    assign start_req   = unl_wr && be[2] && wdata[BIT_STRT];
    assign start_busy  = start_req && busy;
    assign start_ok    = start_req && !busy && !strt;
    assign relock_req  = wr && be[3] && wdata[BIT_LOCK];
    assign unused_bits = ^{wdata[30:26], wdata[23:17], wdata[15:10], wdata[7]};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q      <= 1'b0;
            start_pulse <= 1'b0;
            pg          <= 1'b0;
            ser         <= 1'b0;
            mer         <= 1'b0;
            snb         <= '0;
            psize       <= '0;
            strt        <= 1'b0;
            eopie       <= 1'b0;
            errie       <= 1'b0;
        end else begin
            busy_q      <= busy;
            start_pulse <= start_ok;
            if (unl_wr && !busy && be[0]) begin
                pg  <= wdata[BIT_PG];
                ser <= wdata[BIT_SER];
                mer <= wdata[BIT_MER];
                snb <= wdata[SNB_LSB +: SNB_W];
            end
            if (unl_wr && !busy && be[1]) psize <= wdata[PSZ_LSB +: PSZ_W];
            if (unl_wr && be[3]) begin
                eopie <= wdata[BIT_EOPIE];
                errie <= wdata[BIT_ERRIE];
            end
            if (start_ok)            strt <= 1'b1;
            else if (busy_q && !busy) strt <= 1'b0;
        end
    end
endmodule

// File: rtl/flashreg_status.sv
module flashreg_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr_wr,
    input  logic [1:0] clr_bits,
    input  logic       done,
    input  logic       err_evt,
    input  logic       eopie,
    input  logic       errie,
    output logic       eop,
    output logic       operr,
    output logic       irq
);
    logic set_eop;
    logic set_err;

    assign set_eop = done && eopie;
    assign set_err = err_evt && errie;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eop   <= 1'b0;
            operr <= 1'b0;
        end else begin
            if (set_eop)                     eop <= 1'b1;
            else if (clr_wr && clr_bits[0])  eop <= 1'b0;
            if (set_err)                     operr <= 1'b1;
            else if (clr_wr && clr_bits[1])  operr <= 1'b0;
        end
    end

    assign irq = (eop && eopie) || (operr && errie);
endmodule

// File: rtl/flashreg_top.sv
module flashreg_top
    import flashreg_pkg::*;
#(
    parameter logic [31:0] KEY1 = 32'h1A2B_3C4D,
    parameter logic [31:0] KEY2 = 32'hE5F6_0718
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic [1:0]       bus_idx,
    input  logic [31:0]      bus_wdata,
    input  logic [3:0]       bus_be,
    output logic [31:0]      bus_rdata,
    input  logic             eng_busy,
    input  logic             eng_done,
    input  logic             eng_err,
    output logic             op_start,
    output logic             op_pg,
    output logic             op_ser,
    output logic             op_mer,
    output logic [SNB_W-1:0] op_sector,
    output logic [PSZ_W-1:0] op_psize,
    output logic             irq
);
    logic wr_key, wr_stat, wr_ctrl;
    logic lk_locked, lk_dead, relock_req;
    logic strt, eopie, errie, start_busy;
    logic eop, operr;

    assign wr_key  = bus_wr && (bus_idx == IDX_KEY);
    assign wr_stat = bus_wr && (bus_idx == IDX_STAT);
    assign wr_ctrl = bus_wr && (bus_idx == IDX_CTRL);

    flashreg_lockfsm #(.KEY1(KEY1), .KEY2(KEY2)) u_lock (
        .clk(clk), .rst_n(rst_n),
        .key_wr(wr_key), .key_full(&bus_be), .key_data(bus_wdata),
        .relock_req(relock_req), .locked(lk_locked), .dead(lk_dead)
    );

    flashreg_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr(wr_ctrl), .be(bus_be), .wdata(bus_wdata),
        .locked(lk_locked), .busy(eng_busy),
        .pg(op_pg), .ser(op_ser), .mer(op_mer), .snb(op_sector), .psize(op_psize),
        .strt(strt), .eopie(eopie), .errie(errie),
        .start_pulse(op_start), .start_busy(start_busy), .relock_req(relock_req)
    );

    flashreg_status u_stat (
        .clk(clk), .rst_n(rst_n),
        .clr_wr(wr_stat && bus_be[0]), .clr_bits(bus_wdata[1:0]),
        .done(eng_done), .err_evt(eng_err || start_busy),
        .eopie(eopie), .errie(errie),
        .eop(eop), .operr(operr), .irq(irq)
    );

    always_comb begin
        bus_rdata = '0;
        unique case (bus_idx)
            IDX_STAT: bus_rdata = {30'b0, operr, eop};
            IDX_CTRL: begin
                bus_rdata[BIT_LOCK]              = lk_locked;
                bus_rdata[BIT_ERRIE]             = errie;
                bus_rdata[BIT_EOPIE]             = eopie;
                bus_rdata[BIT_STRT]              = strt;
                bus_rdata[PSZ_LSB +: PSZ_W]      = op_psize;
                bus_rdata[SNB_LSB +: SNB_W]      = op_sector;
                bus_rdata[BIT_MER]               = op_mer;
                bus_rdata[BIT_SER]               = op_ser;
                bus_rdata[BIT_PG]                = op_pg;
            end
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/flashreg_chk.sv
module flashreg_chk
    import flashreg_pkg::*;
#(
    parameter logic [31:0] KEY2 = 32'hE5F6_0718
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [1:0]       bus_idx,
    input logic [31:0]      bus_wdata,
    input logic [3:0]       bus_be,
    input logic             eng_busy,
    input logic             eng_done,
    input logic             op_start,
    input logic             op_pg,
    input logic             op_ser,
    input logic             op_mer,
    input logic [SNB_W-1:0] op_sector,
    input logic [PSZ_W-1:0] op_psize,
    input logic             irq,
    input logic             locked,
    input logic             dead,
    input logic             eop,
    input logic             operr,
    input logic             eopie
);
    a_r2_unlock_needs_key2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(locked) |-> $past(bus_wr && bus_idx == IDX_KEY && bus_wdata == KEY2 && bus_be == 4'hF));

    a_r3_dead_is_final: assert property (@(posedge clk) disable iff (!rst_n)
        dead |=> (dead && locked));

    a_r5_locked_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        locked |=> $stable({op_pg, op_ser, op_mer, op_sector, op_psize}));

    a_r7_start_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        op_start |=> !op_start);

    a_r9_busy_fields_hold: assert property (@(posedge clk) disable iff (!rst_n)
        eng_busy |=> ($stable({op_pg, op_ser, op_mer, op_sector, op_psize}) && !op_start));

    a_r10_eop_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(eop) |-> $past(eng_done && eopie));

    a_r13_irq_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (eop || operr));
endmodule

bind flashreg_top flashreg_chk #(.KEY2(KEY2)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_idx(bus_idx),
    .bus_wdata(bus_wdata), .bus_be(bus_be), .eng_busy(eng_busy), .eng_done(eng_done),
    .op_start(op_start), .op_pg(op_pg), .op_ser(op_ser), .op_mer(op_mer),
    .op_sector(op_sector), .op_psize(op_psize), .irq(irq),
    .locked(lk_locked), .dead(lk_dead), .eop(eop), .operr(operr), .eopie(eopie)
);

// File: tb/flashreg_top_test.sv
module flashreg_top_test;
    localparam int CLK_PERIOD = 10;
    localparam logic [31:0] K1 = 32'h1A2B_3C4D;
    localparam logic [31:0] K2 = 32'hE5F6_0718;
    localparam logic [31:0] RSV = 32'h7CFE_FC80;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic bus_wr = 1'b0;
    logic [1:0] bus_idx = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [3:0] bus_be = '0;
    logic [31:0] bus_rdata;
    logic eng_busy = 1'b0, eng_done = 1'b0, eng_err = 1'b0;
    logic op_start, op_pg, op_ser, op_mer, irq;
    logic [3:0] op_sector;
    logic [1:0] op_psize;
    int checks = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flashreg_top uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_idx(bus_idx),
        .bus_wdata(bus_wdata), .bus_be(bus_be), .bus_rdata(bus_rdata),
        .eng_busy(eng_busy), .eng_done(eng_done), .eng_err(eng_err),
        .op_start(op_start), .op_pg(op_pg), .op_ser(op_ser), .op_mer(op_mer),
        .op_sector(op_sector), .op_psize(op_psize), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] idx, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_wr = 1'b1; bus_idx = idx; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input logic [1:0] idx, output logic [31:0] d);
        bus_idx = idx; #1; d = bus_rdata;
    endtask

    task automatic unlock();
        wr(2'd0, K1, 4'hF);
        wr(2'd0, K2, 4'hF);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [31:0] r, d;
        do_reset();
        // R1 reset state
        rd(2'd2, r); check("R1 ctrl", r, 32'h8000_0000);
        rd(2'd1, r); check("R1 stat", r, 0);
        check("R1 irq", {31'b0, irq}, 0);
        check("R1 op_start", {31'b0, op_start}, 0);
        // R5 locked writes ignored
        wr(2'd2, 32'h0300_03FF, 4'hF);
        rd(2'd2, r); check("R5 locked write", r, 32'h8000_0000);
        check("R5 op ports", {26'b0, op_psize, op_sector}, 0);
        // R2 unlock
        unlock();
        rd(2'd2, r); check("R2 unlocked", r, 0);
        // R6 field sweep with reserved bits set
        for (int f = 0; f < 512; f++) begin
            d = ({22'b0, f[8:7], 8'b0} | {25'b0, f[6:0]}) ;
            d = (32'(f[8:7]) << 8) | (32'(f[6:3]) << 3) | 32'(f[2:0]);
            wr(2'd2, d | RSV, 4'hF);
            rd(2'd2, r); check("R6 field readback", r, d);
            check("R6 op ports", {23'b0, op_psize, op_sector, op_mer, op_ser, op_pg},
                  {23'b0, f[8:7], f[6:3], f[2], f[1], f[0]});
        end
        // R6 byte lanes: only lane 1 disabled, psize keeps 3
        wr(2'd2, 32'h0000_0000, 4'b1101);
        rd(2'd2, r); check("R6 byte enable", r, 32'h0000_0300);
        // R7 start with 0 does nothing, then with 1
        wr(2'd2, 32'h0000_0000, 4'b0100);
        check("R7 zero no pulse", {31'b0, op_start}, 0);
        wr(2'd2, 32'h0001_0000, 4'b0100);
        check("R7 pulse", {31'b0, op_start}, 1);
        rd(2'd2, r); check("R7 strt set", r, 32'h0001_0300);
        @(negedge clk); check("R7 pulse one cycle", {31'b0, op_start}, 0);
        // R9 busy
        eng_busy = 1'b1;
        repeat (2) @(negedge clk);
        wr(2'd2, 32'h0000_02FF, 4'b0011);
        rd(2'd2, r); check("R9 busy fields", r, 32'h0001_0300);
        wr(2'd2, 32'h0001_0000, 4'b0100);
        check("R9 no pulse when busy", {31'b0, op_start}, 0);
        rd(2'd1, r); check("R9 R11 no flag without enable", r, 0);
        wr(2'd2, 32'h0200_0000, 4'b1000);
        wr(2'd2, 32'h0001_0000, 4'b0100);
        rd(2'd1, r); check("R9 R11 busy start error", r, 32'h2);
        check("R13 irq on error", {31'b0, irq}, 1);
        wr(2'd1, 32'h2, 4'h1);
        rd(2'd1, r); check("R12 clear error", r, 0);
        // R8 busy falls
        eng_busy = 1'b0;
        @(negedge clk);
        rd(2'd2, r); check("R8 strt cleared", r, 32'h0200_0300);
        wr(2'd2, 32'h0, 4'b1000);
        // R10 R11 R12 R13 enable sweep
        for (int m = 0; m < 4; m++) begin
            wr(2'd2, 32'(m) << 24, 4'b1000);
            @(negedge clk); eng_done = 1'b1; eng_err = 1'b1;
            @(negedge clk); eng_done = 1'b0; eng_err = 1'b0;
            rd(2'd1, r); check("R10 R11 flags", r, 32'(m));
            check("R13 irq", {31'b0, irq}, {31'b0, (m != 0)});
            wr(2'd1, 32'h0, 4'h1);
            rd(2'd1, r); check("R12 write zero", r, 32'(m));
            if (m == 3) begin
                wr(2'd2, 32'h0, 4'b1000);
                check("R13 irq masked", {31'b0, irq}, 0);
                rd(2'd1, r); check("R13 flags kept", r, 32'h3);
            end
            wr(2'd1, 32'h3, 4'h1);
            rd(2'd1, r); check("R12 write one", r, 0);
        end
        // R4 relock
        wr(2'd2, 32'h0, 4'b1000);
        rd(2'd2, r); check("R4 zero no lock", r, 32'h0000_0300);
        wr(2'd2, 32'h8000_0000, 4'b1000);
        rd(2'd2, r); check("R4 relock", r, 32'h8000_0300);
        wr(2'd2, 32'h0000_0001, 4'hF);
        rd(2'd2, r); check("R5 relocked ignores", r, 32'h8000_0300);
        unlock();
        rd(2'd2, r); check("R4 unlock again", r, 32'h0000_0300);
        // R3 bad sequences
        for (int p = 0; p < 4; p++) begin
            do_reset();
            case (p)
                0: begin wr(2'd0, K2, 4'hF); end
                1: begin wr(2'd0, K1, 4'hF); wr(2'd0, 32'h0, 4'hF); end
                2: begin wr(2'd0, K1, 4'b0111); end
                default: begin wr(2'd0, K1, 4'hF); wr(2'd0, K1, 4'hF); end
            endcase
            unlock();
            rd(2'd2, r); check("R3 stays locked", r, 32'h8000_0000);
            wr(2'd2, 32'h0000_0001, 4'hF);
            rd(2'd2, r); check("R3 R5 write ignored", r, 32'h8000_0000);
        end
        for (int b = 0; b < 32; b++) begin
            do_reset();
            wr(2'd0, K1 ^ (32'h1 << b), 4'hF);
            wr(2'd0, K2, 4'hF);
            unlock();
            rd(2'd2, r); check("R3 flipped key", r, 32'h8000_0000);
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule